// File: doc/BRIEF.md
# Accumulator ALU with Register Banks

This block is an 8-bit accumulator datapath. It holds an accumulator, six general registers (B, C, D, E, H, L) and an alternate copy of those six. It also holds a status word with zero, sign and carry bits. Each cycle with the valid strobe high, it performs one operation. The operation is given by an operation code, a destination select, a source select and an 8-bit immediate. All state updates on the rising clock edge.

Add and subtract always take the accumulator as one operand and write their result back to it. Increment and decrement work on single registers or on register pairs. The accumulator can be inverted or negated. Loads copy a register or an immediate into a register. One operation exchanges all three pairs with their alternate copies. Each class of operation has its own rule for which status bits it changes.

A combinational observation port reads any register by its select code. The accumulator and status bits are also driven out directly. The block is single-cycle, so its control has no multi-state sequencer.

Top module: `acc_alu_core`

Register select codes: 0 B, 1 C, 2 D, 3 E, 4 H, 5 L, 6 none (reads as 0), 7 accumulator. Pair codes on `dst_sel[1:0]`: 0 BC, 1 DE, 2 HL, 3 none. The first-named register of a pair is the high byte. Operation codes: 0 load register, 1 load immediate, 2 add register, 3 add immediate, 4 subtract register, 5 subtract immediate, 6 increment 8-bit, 7 decrement 8-bit, 8 increment pair, 9 decrement pair, 10 invert, 11 negate, 12 exchange, 13 to 15 no operation.

## Requirements
- R1: After reset, all registers, alternate registers, the accumulator and the zero, sign and carry bits read 0.
- R2: Codes 2 and 3 set the accumulator to (accumulator + operand) mod 256. The operand is the source register for code 2 and the immediate for code 3. Carry is set to the carry out of bit 7, zero to (result == 0) and sign to result bit 7.
- R3: Codes 4 and 5 set the accumulator to (accumulator - operand) mod 256, leaving a negative result in two's-complement form. Carry is set exactly when the operand exceeds the accumulator, taken unsigned. Zero and sign follow the result.
- R4: Codes 6 and 7 add or subtract 1 (wrapping) to the register selected by `dst_sel`, including the accumulator. Zero and sign follow the result, and carry keeps its value.
- R5: Codes 8 and 9 add or subtract 1 (wrapping at 16 bits) to the pair selected by `dst_sel[1:0]`. No status bit changes.
- R6: Code 0 copies the source register into the destination and code 1 copies the immediate into the destination. The source is left unchanged and no status bit changes.
- R7: Code 12 swaps all three pairs with their alternate copies in one cycle, leaving the accumulator and status bits unchanged. A second exchange restores the first bank.
- R8: Code 10 replaces the accumulator with its bitwise inverse and changes no status bit.
- R9: Code 11 replaces the accumulator with (0 - accumulator) mod 256. Carry is set exactly when the old accumulator was nonzero, and zero and sign follow the result.
- R10: With `op_valid` low, with codes 13 to 15, with pair code 3 on codes 8 and 9, or with destination code 6 on codes 0, 1, 6 and 7, no register or status bit changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Performs the presented operation at this edge |
| op_code | input | 4 | Operation code |
| dst_sel | input | 3 | Destination register code; bits 1:0 select a pair |
| src_sel | input | 3 | Source register code |
| imm | input | 8 | Immediate operand |
| obs_sel | input | 3 | Register code for the observation port |
| obs_data | output | 8 | Current value of the register named by `obs_sel` |
| acc_q | output | 8 | Accumulator |
| flag_z | output | 1 | Zero bit |
| flag_s | output | 1 | Sign bit |
| flag_c | output | 1 | Carry bit |

## Verification
The assertions assume that `op_valid`, `op_code`, `imm` and the selects hold known values at every rising edge after reset. They also assume that the result of an operation is visible on the accumulator and status outputs one cycle after the strobe. The stimulus changes inputs only on falling edges, always drives defined values, and mixes invalid codes, the unused register code and the unused pair code into random operations. This way the properties on status-bit preservation are reached through every operation class.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
    localparam int DW      = 8;
    localparam int SELW    = 3;
    localparam int NGEN    = 6;
    localparam int NPAIR   = NGEN / 2;
    localparam logic [SELW-1:0] SEL_NONE = 3'd6;
    localparam logic [SELW-1:0] SEL_ACC  = 3'd7;

    typedef enum logic [3:0] {
        OP_LDR  = 4'd0,
        OP_LDI  = 4'd1,
        OP_ADDR = 4'd2,
        OP_ADDI = 4'd3,
        OP_SUBR = 4'd4,
        OP_SUBI = 4'd5,
        OP_INC  = 4'd6,
        OP_DEC  = 4'd7,
        OP_INCW = 4'd8,
        OP_DECW = 4'd9,
        OP_INV  = 4'd10,
        OP_NEG  = 4'd11,
        OP_XCH  = 4'd12
    } op_e;

    typedef struct packed {
        logic          acc_we;
        logic          dst_we;
        logic          pair_we;
        logic          swap;
        logic          zs_we;
        logic          c_we;
        logic [DW-1:0] res;
        logic [2*DW-1:0] pair_res;
        logic          z;
        logic          s;
        logic          c;
    } exec_t;
endpackage

// File: rtl/acc_alu_bank.sv
module acc_alu_bank
    import acc_alu_pkg::*;
#(
    parameter int W  = DW,
    parameter int N  = NGEN,
    parameter int NR = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [SELW-1:0] wr_sel,
    input  logic [W-1:0]    wr_data,
    input  logic            pair_we,
    input  logic [1:0]      pair_sel,
    input  logic [2*W-1:0]  pair_data,
    input  logic            swap,
    input  logic [SELW-1:0] rd_sel  [NR],
    output logic [W-1:0]    rd_data [NR],
    output logic [2*W-1:0]  pair_q
);
    localparam int NP = N / 2;

    logic [W-1:0] main_r [N];
    logic [W-1:0] alt_r  [N];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                main_r[i] <= '0;
                alt_r[i]  <= '0;
            end
        end else if (swap) begin
            for (int i = 0; i < N; i++) begin
                main_r[i] <= alt_r[i];
                alt_r[i]  <= main_r[i];
            end
        end else if (pair_we && (int'(pair_sel) < NP)) begin
            main_r[{pair_sel, 1'b0}] <= pair_data[2*W-1:W];
            main_r[{pair_sel, 1'b1}] <= pair_data[W-1:0];
        end else if (wr_en && (int'(wr_sel) < N)) begin
            main_r[wr_sel] <= wr_data;
        end
    end

    generate
        for (genvar g = 0; g < NR; g++) begin : g_rd
            assign rd_data[g] = (int'(rd_sel[g]) < N) ? main_r[rd_sel[g]] : '0;
        end
    endgenerate

    assign pair_q = (int'(pair_sel) < NP) ?
                    {main_r[{pair_sel, 1'b0}], main_r[{pair_sel, 1'b1}]} : '0;
endmodule

// File: rtl/acc_alu_exec.sv
module acc_alu_exec
    import acc_alu_pkg::*;
(
    input  logic [3:0]      op_code,
    input  logic [DW-1:0]   acc,
    input  logic [DW-1:0]   src_val,
    input  logic [DW-1:0]   dst_val,
    input  logic [DW-1:0]   imm,
    input  logic [2*DW-1:0] pair_val,
    output exec_t           ex
);
    logic [DW:0]   wide;
    logic [DW-1:0] opnd;

    always_comb begin
        ex   = '0;
        wide = '0;
        opnd = (op_code == OP_ADDI || op_code == OP_SUBI) ? imm : src_val;
        case (op_code)
            OP_LDR: begin
                ex.dst_we = 1'b1;
                ex.res    = src_val;
            end
            OP_LDI: begin
                ex.dst_we = 1'b1;
                ex.res    = imm;
            end
            OP_ADDR, OP_ADDI: begin
                wide     = {1'b0, acc} + {1'b0, opnd};
                ex.acc_we = 1'b1;
                ex.zs_we  = 1'b1;
                ex.c_we   = 1'b1;
                ex.res    = wide[DW-1:0];
                ex.c      = wide[DW];
            end
            OP_SUBR, OP_SUBI: begin
                wide     = {1'b0, acc} - {1'b0, opnd};
                ex.acc_we = 1'b1;
                ex.zs_we  = 1'b1;
                ex.c_we   = 1'b1;
                ex.res    = wide[DW-1:0];
                ex.c      = wide[DW];
            end
            OP_INC, OP_DEC: begin
                ex.dst_we = 1'b1;
                ex.zs_we  = 1'b1;
                ex.res    = (op_code == OP_INC) ? dst_val + 1'b1 : dst_val - 1'b1;
            end
            OP_INCW: begin
                ex.pair_we  = 1'b1;
                ex.pair_res = pair_val + 1'b1;
            end
            OP_DECW: begin
                ex.pair_we  = 1'b1;
                ex.pair_res = pair_val - 1'b1;
            end
            OP_INV: begin
                ex.acc_we = 1'b1;
                ex.res    = ~acc;
            end
            OP_NEG: begin
                ex.acc_we = 1'b1;
                ex.zs_we  = 1'b1;
                ex.c_we   = 1'b1;
                ex.res    = '0 - acc;
                ex.c      = |acc;
            end
            OP_XCH: ex.swap = 1'b1;
            default: ex = '0;
        endcase
        ex.z = (ex.res == '0);
        ex.s = ex.res[DW-1];
    end
endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
    import acc_alu_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic [3:0]      op_code,
    input  logic [SELW-1:0] dst_sel,
    input  logic [SELW-1:0] src_sel,
    input  logic [DW-1:0]   imm,
    input  logic [SELW-1:0] obs_sel,
    output logic [DW-1:0]   obs_data,
    output logic [DW-1:0]   acc_q,
    output logic            flag_z,
    output logic            flag_s,
    output logic            flag_c
);
    localparam int NR = 3;

    logic [SELW-1:0] rd_sel  [NR];
    logic [DW-1:0]   rd_data [NR];
    logic [2*DW-1:0] pair_q;
    logic [DW-1:0]   src_val, dst_val;
    logic            dst_used, go;
    exec_t           ex;

    assign rd_sel[0] = src_sel;
    assign rd_sel[1] = dst_sel;
    assign rd_sel[2] = obs_sel;

    assign src_val  = (src_sel == SEL_ACC) ? acc_q : rd_data[0];
    assign dst_val  = (dst_sel == SEL_ACC) ? acc_q : rd_data[1];
    assign obs_data = (obs_sel == SEL_ACC) ? acc_q : rd_data[2];

    assign dst_used = (op_code == OP_LDR) || (op_code == OP_LDI) ||
                      (op_code == OP_INC) || (op_code == OP_DEC);
    assign go       = op_valid && !(dst_used && dst_sel == SEL_NONE);

    acc_alu_exec u_exec (
        .op_code  (op_code),
        .acc      (acc_q),
        .src_val  (src_val),
        .dst_val  (dst_val),
        .imm      (imm),
        .pair_val (pair_q),
        .ex       (ex)
    );

    acc_alu_bank #(.W(DW), .N(NGEN), .NR(NR)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (go && ex.dst_we && dst_sel != SEL_ACC),
        .wr_sel    (dst_sel),
        .wr_data   (ex.res),
        .pair_we   (go && ex.pair_we),
        .pair_sel  (dst_sel[1:0]),
        .pair_data (ex.pair_res),
        .swap      (go && ex.swap),
        .rd_sel    (rd_sel),
        .rd_data   (rd_data),
        .pair_q    (pair_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q  <= '0;
            flag_z <= 1'b0;
            flag_s <= 1'b0;
            flag_c <= 1'b0;
        end else if (go) begin
            if (ex.acc_we || (ex.dst_we && dst_sel == SEL_ACC))
                acc_q <= ex.res;
            if (ex.zs_we) begin
                flag_z <= ex.z;
                flag_s <= ex.s;
            end
            if (ex.c_we)
                flag_c <= ex.c;
        end
    end
endmodule

// File: rtl/acc_alu_core_chk.sv
module acc_alu_core_chk
    import acc_alu_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            op_valid,
    input logic [3:0]      op_code,
    input logic [SELW-1:0] dst_sel,
    input logic [SELW-1:0] src_sel,
    input logic [DW-1:0]   imm,
    input logic [SELW-1:0] obs_sel,
    input logic [DW-1:0]   obs_data,
    input logic [DW-1:0]   acc_q,
    input logic            flag_z,
    input logic            flag_s,
    input logic            flag_c
);
    assert_add_imm_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_ADDI) |=>
            (acc_q == DW'($past(acc_q) + $past(imm))) && (flag_z == (acc_q == '0)));

    assert_sub_borrow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_SUBI) |=> (flag_c == ($past(imm) > $past(acc_q))));

    assert_step_keeps_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == OP_INC || op_code == OP_DEC)) |=> $stable(flag_c));

    assert_pair_step_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == OP_INCW || op_code == OP_DECW)) |=>
            ($stable(flag_z) && $stable(flag_s) && $stable(flag_c) && $stable(acc_q)));

    assert_load_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == OP_LDR || op_code == OP_LDI)) |=>
            ($stable(flag_z) && $stable(flag_s) && $stable(flag_c)));

    assert_exchange_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_XCH) |=>
            ($stable(acc_q) && $stable(flag_z) && $stable(flag_s) && $stable(flag_c)));

    assert_invert_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_INV) |=>
            ((acc_q == ~$past(acc_q)) && $stable(flag_z) && $stable(flag_s) && $stable(flag_c)));

    assert_negate_carry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_NEG) |=>
            ((flag_c == ($past(acc_q) != '0)) && (flag_s == acc_q[DW-1])));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid || op_code > 4'd12) |=>
            ($stable(acc_q) && $stable(flag_z) && $stable(flag_s) && $stable(flag_c)));
endmodule

bind acc_alu_core acc_alu_core_chk u_chk (.*);

// File: tb/acc_alu_core_tb.sv
`timescale 1ns/100ps
module acc_alu_core_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [3:0] op_code = '0;
    logic [2:0] dst_sel = '0, src_sel = '0, obs_sel = '0;
    logic [7:0] imm = '0;
    logic [7:0] obs_data, acc_q;
    logic       flag_z, flag_s, flag_c;

    int n_chk = 0, n_bad = 0;

    logic [7:0] m_r [8];
    logic [7:0] m_alt [6];
    logic       m_z, m_s, m_c;

    always #5 clk = ~clk;

    acc_alu_core u_dut (.*);

    function automatic logic [7:0] mrd(input logic [2:0] sel);
        return (sel == 3'd6) ? 8'h00 : m_r[sel];
    endfunction

    function automatic string req_of(input logic [3:0] op, input logic v);
        if (!v || op > 4'd12) return "R10";
        case (op)
            4'd0, 4'd1: return "R6";
            4'd2, 4'd3: return "R2";
            4'd4, 4'd5: return "R3";
            4'd6, 4'd7: return "R4";
            4'd8, 4'd9: return "R5";
            4'd10: return "R8";
            4'd11: return "R9";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp_v);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp_v);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 8; i++) m_r[i] = '0;
        for (int i = 0; i < 6; i++) m_alt[i] = '0;
        {m_z, m_s, m_c} = '0;
    endtask

    task automatic model(input logic v, input logic [3:0] op, input logic [2:0] d,
                         input logic [2:0] s, input logic [7:0] im);
        logic [8:0]  t;
        logic [7:0]  x, a;
        logic [15:0] w;
        logic [1:0]  p;
        if (!v) return;
        a = m_r[7];
        p = d[1:0];
        case (op)
            4'd0: if (d != 3'd6) m_r[d] = mrd(s);
            4'd1: if (d != 3'd6) m_r[d] = im;
            4'd2, 4'd3: begin
                x = (op == 4'd3) ? im : mrd(s);
                t = a + x;
                m_r[7] = t[7:0]; m_c = t[8];
                m_z = (t[7:0] == 0); m_s = t[7];
            end
            4'd4, 4'd5: begin
                x = (op == 4'd5) ? im : mrd(s);
                m_c = (x > a);
                m_r[7] = a - x;
                m_z = (m_r[7] == 0); m_s = m_r[7][7];
            end
            4'd6, 4'd7: if (d != 3'd6) begin
                x = (op == 4'd6) ? m_r[d] + 8'd1 : m_r[d] - 8'd1;
                m_r[d] = x;
                m_z = (x == 0); m_s = x[7];
            end
            4'd8, 4'd9: if (p != 2'd3) begin
                w = {m_r[2*p], m_r[2*p+1]};
                w = (op == 4'd8) ? w + 16'd1 : w - 16'd1;
                m_r[2*p] = w[15:8]; m_r[2*p+1] = w[7:0];
            end
            4'd10: m_r[7] = ~a;
            4'd11: begin
                m_c = (a != 0);
                m_r[7] = 8'd0 - a;
                m_z = (m_r[7] == 0); m_s = m_r[7][7];
            end
            4'd12: for (int i = 0; i < 6; i++) begin
                x = m_r[i]; m_r[i] = m_alt[i]; m_alt[i] = x;
            end
            default: ;
        endcase
    endtask

    task automatic compare_all(input string req);
        #1;
        check(acc_q == m_r[7], req, acc_q, m_r[7]);
        check({flag_z, flag_s, flag_c} == {m_z, m_s, m_c}, req,
              {flag_z, flag_s, flag_c}, {m_z, m_s, m_c});
        for (int i = 0; i < 8; i++) begin
            obs_sel = 3'(i);
            #0.2;
            check(obs_data == mrd(3'(i)), req, obs_data, mrd(3'(i)));
        end
    endtask

    task automatic do_op(input logic v, input logic [3:0] op, input logic [2:0] d,
                         input logic [2:0] s, input logic [7:0] im);
        @(negedge clk);
        op_valid = v; op_code = op; dst_sel = d; src_sel = s; imm = im;
        @(posedge clk);
        model(v, op, d, s, im);
        #1 op_valid = 1'b0;
        compare_all(req_of(op, v));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : stim
        int seed;
        logic [31:0] rv;
        seed = 1234;
        rv = $urandom(seed);
        model_reset();
        repeat (3) @(posedge clk);
        #1 compare_all("R1");
        @(negedge clk) rst_n = 1'b1;

        // R2: wrap to zero with carry
        do_op(1, 4'd1, 3'd7, 3'd0, 8'hFF);
        do_op(1, 4'd3, 3'd0, 3'd0, 8'h01);
        check(acc_q == 8'h00 && flag_z && flag_c, "R2", {acc_q, flag_z, flag_c}, 10'h003);
        // R3: borrow into negative
        do_op(1, 4'd5, 3'd0, 3'd0, 8'h01);
        check(acc_q == 8'hFF && flag_s && flag_c, "R3", {acc_q, flag_s, flag_c}, 10'h3FF);
        // R4: increment keeps carry set
        do_op(1, 4'd6, 3'd7, 3'd0, 8'h00);
        check(acc_q == 8'h00 && flag_z && flag_c, "R4", {acc_q, flag_z, flag_c}, 10'h003);
        // R9: negate of zero clears carry
        do_op(1, 4'd11, 3'd0, 3'd0, 8'h00);
        check(!flag_c && flag_z, "R9", {flag_z, flag_c}, 2'b10);
        // R5: HL wraps from FFFF
        do_op(1, 4'd1, 3'd4, 3'd0, 8'hFF);
        do_op(1, 4'd1, 3'd5, 3'd0, 8'hFF);
        do_op(1, 4'd8, 3'd2, 3'd0, 8'h00);
        // R7: two exchanges restore
        do_op(1, 4'd1, 3'd0, 3'd0, 8'h5A);
        do_op(1, 4'd12, 3'd0, 3'd0, 8'h00);
        do_op(1, 4'd12, 3'd0, 3'd0, 8'h00);
        // R10: unused destination and pair codes
        do_op(1, 4'd1, 3'd6, 3'd0, 8'h77);
        do_op(1, 4'd9, 3'd3, 3'd0, 8'h00);

        for (int k = 0; k < 3000; k++) begin
            rv = $urandom();
            do_op(rv[31:28] != 4'd0, 4'(rv[3:0] % 14), rv[6:4], rv[9:7], rv[17:10]);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule